// File: doc/BRIEF.md
# Three-Level Shoot-Through Space-Vector Gate Sequencer

This block produces the nine leg gates and the two boost-network gates for a three-phase, three-level T-type bridge. The bridge sits behind a split boost stage. A free-running counter divides time into carrier periods of `PERIOD` clock cycles. In each period the block plays a symmetric sequence of space vectors: half of the zero time, half of the medium time, the whole large time, the other half of the medium time, and the rest of the zero time. The vectors are drawn only from the zero vector, the medium vectors and the large vectors. The small vectors are never used, which keeps the common-mode voltage within one sixth of the link voltage.

A higher-level controller supplies, once per period, a sector number and four cycle counts: the medium dwell, the large dwell, the shoot-through time and the boost-switch on time. The zero dwell is what remains of the period. Shoot-through turns on every switch of every leg. It is placed only inside the two zero-vector slots, so the boost action adds no distortion to the line voltages. The boost switches conduct right after the leading shoot-through slot and are never on during shoot-through. Requests that break the duty limits are clamped and flagged. All inputs are taken only at the period boundary.

Top module: `tl_st_modulator`

## Requirements
- R1: Outside shoot-through, each leg (bit 0 = leg A, bit 1 = leg B, bit 2 = leg C) has exactly one of its three gates on. A high gate means level P, a middle gate means level O and a low gate means level N.
- R2: With s = clamped shoot-through count, sa = floor(s/2) and sb = s - sa, all nine leg gates are on at period positions 0 to sa-1 and at positions PERIOD-sb to PERIOD-1, and at no other position. Both ranges lie within the zero-vector slots.
- R3: With z = PERIOD - tm - tl and za = floor(z/2), positions below za are zero vector (OOO). The next floor(tm/2) positions are the medium vector, the next tl positions are the large vector, and the next tm - floor(tm/2) positions are the medium vector again. The rest of the period is the zero vector.
- R4: Sector k (1..12) uses medium vector index (k-1)/2 from the list PON, OPN, NPO, NOP, ONP, PNO and large vector index (k/2) mod 6 from the list PNN, PPN, NPN, NPP, NNP, PNP. Integer division is used, and each string lists the legs A, B, C in that order.
- R5: Every applied non-shoot-through vector has a count of P legs and a count of N legs that differ by at most one, so the common-mode level stays within plus or minus one sixth of the link.
- R6: Both boost gates are equal and are on exactly at positions sa to sa+d-1, where d is the clamped boost count. They are therefore off during shoot-through.
- R7: The clamping works as follows: tm = min(tm, PERIOD), tl = min(tl, PERIOD - tm), s = min(s, z, PERIOD-1) and d = min(d, PERIOD-1-s). The clamp flag is high for the whole period if any of these values changed or the sector was invalid.
- R8: Inputs are sampled only in the last cycle of a period, and the sampled values take effect at position 0 of the next period. A change in the middle of a period has no effect on that period.
- R9: A sector value of 0 or greater than 12 gives the zero vector for the whole period, because tm and tl are forced to 0. It also raises the clamp flag. Shoot-through and boost still follow their counts.
- R10: During reset all gates and the flag are low. The first period after reset is the zero vector with no shoot-through and no boost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_i | input | 4 | Sector number, 1 to 12 |
| t_med_i | input | CW | Medium vector dwell in cycles |
| t_lrg_i | input | CW | Large vector dwell in cycles |
| t_st_i | input | CW | Shoot-through cycles per period |
| t_bst_i | input | CW | Boost-switch on cycles per period |
| gate_hi_o | output | 3 | High (P) gate per leg |
| gate_mid_o | output | 3 | Middle (O) gate per leg |
| gate_lo_o | output | 3 | Low (N) gate per leg |
| boost_p_o | output | 1 | Upper boost-network switch gate |
| boost_n_o | output | 1 | Lower boost-network switch gate |
| clamp_o | output | 1 | Request was clamped or the sector was invalid |

## Verification
All twelve sectors are swept with five dwell patterns on a 20-cycle period, and every position of every period is compared. The patterns use odd and even dwells, a zero vector filled entirely by shoot-through, an empty medium/large time, and the nominal operating ratios. Together they tell apart the symmetric slot boundaries, the rounding of the shoot-through halves and the rotation of the vector table. Clamp patterns push each count past its limit, one at a time, and invalid sector codes separate clamping from the sector fallback. A mid-period input change shows that the running period is not affected.

// File: rtl/tl_st_modulator.sv
module tl_st_modulator #(
  parameter int PERIOD = 40000,
  parameter int CW     = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    sector_i,
  input  logic [CW-1:0] t_med_i,
  input  logic [CW-1:0] t_lrg_i,
  input  logic [CW-1:0] t_st_i,
  input  logic [CW-1:0] t_bst_i,
  output logic [2:0]    gate_hi_o,
  output logic [2:0]    gate_mid_o,
  output logic [2:0]    gate_lo_o,
  output logic          boost_p_o,
  output logic          boost_n_o,
  output logic          clamp_o
);

  localparam logic [CW-1:0] TP    = CW'(PERIOD);
  localparam logic [CW-1:0] TLAST = CW'(PERIOD - 1);
  localparam logic [1:0] LN = 2'b00;
  localparam logic [1:0] LO = 2'b01;
  localparam logic [1:0] LP = 2'b10;
  localparam logic [5:0] VZERO = {LO, LO, LO};

  function automatic logic [5:0] med_vec(input logic [2:0] i);
    case (i)
      3'd0:    return {LN, LO, LP};
      3'd1:    return {LN, LP, LO};
      3'd2:    return {LO, LP, LN};
      3'd3:    return {LP, LO, LN};
      3'd4:    return {LP, LN, LO};
      default: return {LO, LN, LP};
    endcase
  endfunction

  function automatic logic [5:0] lrg_vec(input logic [2:0] i);
    case (i)
      3'd1:    return {LN, LP, LP};
      3'd2:    return {LN, LP, LN};
      3'd3:    return {LP, LP, LN};
      3'd4:    return {LP, LN, LN};
      3'd5:    return {LP, LN, LP};
      default: return {LN, LN, LP};
    endcase
  endfunction

  function automatic logic [CW-1:0] umin(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [CW-1:0] cnt;
  logic          wrap;
  assign wrap = (cnt == TLAST);

  logic          sec_ok;
  logic [2:0]    mi, li_raw, li;
  logic [CW-1:0] tm_c, tl_c, tz, st_c, d0_c, ma, sa, sb;
  logic [CW-1:0] b1_n, b2_n, b3_n, b4_n, ste_n, be_n;
  logic          flag_n;

  assign sec_ok = (sector_i >= 4'd1) && (sector_i <= 4'd12);
  assign mi     = 3'((sector_i - 4'd1) >> 1);
  assign li_raw = 3'(sector_i >> 1);
  assign li     = (li_raw == 3'd6) ? 3'd0 : li_raw;

  assign tm_c = sec_ok ? umin(t_med_i, TP) : '0;
  assign tl_c = sec_ok ? umin(t_lrg_i, TP - tm_c) : '0;
  assign tz   = TP - tm_c - tl_c;
  assign st_c = umin(t_st_i, umin(tz, TLAST));
  assign d0_c = umin(t_bst_i, TLAST - st_c);
  assign ma   = tm_c >> 1;
  assign sa   = st_c >> 1;
  assign sb   = st_c - sa;

  assign b1_n  = tz >> 1;
  assign b2_n  = b1_n + ma;
  assign b3_n  = b2_n + tl_c;
  assign b4_n  = b3_n + (tm_c - ma);
  assign ste_n = TP - sb;
  assign be_n  = sa + d0_c;

  assign flag_n = !sec_ok || (tm_c != t_med_i) || (tl_c != t_lrg_i)
               || (st_c != t_st_i) || (d0_c != t_bst_i);

  logic [CW-1:0] b1_q, b2_q, b3_q, b4_q, sa_q, ste_q, be_q;
  logic [5:0]    mvec_q, lvec_q;
  logic          flag_q;

  logic       st_now;
  logic [5:0] vec;
  logic [2:0] hi_n, mid_n, lo_n;

  assign st_now = (cnt < sa_q) || (cnt >= ste_q);
  assign vec    = ((cnt < b1_q) || (cnt >= b4_q)) ? VZERO :
                  ((cnt < b2_q) || (cnt >= b3_q)) ? mvec_q : lvec_q;

  for (genvar g = 0; g < 3; g++) begin : g_leg
    assign hi_n[g]  = st_now || (vec[2*g +: 2] == LP);
    assign mid_n[g] = st_now || (vec[2*g +: 2] == LO);
    assign lo_n[g]  = st_now || (vec[2*g +: 2] == LN);
  end

  logic bst_n;
  assign bst_n = (cnt >= sa_q) && (cnt < be_q);

  logic bst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      b1_q       <= TP;
      b2_q       <= TP;
      b3_q       <= TP;
      b4_q       <= TP;
      sa_q       <= '0;
      ste_q      <= TP;
      be_q       <= '0;
      mvec_q     <= VZERO;
      lvec_q     <= VZERO;
      flag_q     <= 1'b0;
      gate_hi_o  <= '0;
      gate_mid_o <= '0;
      gate_lo_o  <= '0;
      bst_q      <= 1'b0;
      clamp_o    <= 1'b0;
    end else begin
      cnt        <= wrap ? '0 : cnt + 1'b1;
      gate_hi_o  <= hi_n;
      gate_mid_o <= mid_n;
      gate_lo_o  <= lo_n;
      bst_q      <= bst_n;
      clamp_o    <= flag_q;
      if (wrap) begin
        b1_q   <= b1_n;
        b2_q   <= b2_n;
        b3_q   <= b3_n;
        b4_q   <= b4_n;
        sa_q   <= sa;
        ste_q  <= ste_n;
        be_q   <= be_n;
        mvec_q <= med_vec(mi);
        lvec_q <= lrg_vec(li);
        flag_q <= flag_n;
      end
    end
  end

  assign boost_p_o = bst_q;
  assign boost_n_o = bst_q;

endmodule

// File: rtl/tl_st_modulator_chk.sv
module tl_st_modulator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] gate_hi_o,
  input logic [2:0] gate_mid_o,
  input logic [2:0] gate_lo_o,
  input logic       boost_p_o,
  input logic       boost_n_o
);
  logic [2:0] all_on;
  assign all_on = gate_hi_o & gate_mid_o & gate_lo_o;

  p_one_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && all_on == 3'b000) |->
      ($countones({gate_hi_o[0], gate_mid_o[0], gate_lo_o[0]}) == 1 &&
       $countones({gate_hi_o[1], gate_mid_o[1], gate_lo_o[1]}) == 1 &&
       $countones({gate_hi_o[2], gate_mid_o[2], gate_lo_o[2]}) == 1));

  p_st_all_legs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (all_on != 3'b000) |-> (all_on == 3'b111));

  p_cmv_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (all_on == 3'b000) |->
      (($countones(gate_hi_o) <= $countones(gate_lo_o) + 1) &&
       ($countones(gate_lo_o) <= $countones(gate_hi_o) + 1)));

  p_boost_off_st_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (all_on == 3'b111) |-> (!boost_p_o && !boost_n_o));

  p_boost_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boost_p_o == boost_n_o);
endmodule

bind tl_st_modulator tl_st_modulator_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .gate_hi_o(gate_hi_o), .gate_mid_o(gate_mid_o), .gate_lo_o(gate_lo_o),
  .boost_p_o(boost_p_o), .boost_n_o(boost_n_o)
);

// File: tb/test_tl_st_modulator.sv
`timescale 1ns/1ps
module test_tl_st_modulator;
  localparam int T  = 20;
  localparam int CW = $clog2(T + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sector_i = 4'd1;
  logic [CW-1:0] t_med_i = '0, t_lrg_i = '0, t_st_i = '0, t_bst_i = '0;
  logic [2:0] gate_hi_o, gate_mid_o, gate_lo_o;
  logic boost_p_o, boost_n_o, clamp_o;

  always #2.5 clk = ~clk;

  tl_st_modulator #(.PERIOD(T)) i_tl_st_modulator (.*);

  int checks = 0, errors = 0, ecount = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else ecount <= ecount + 1;
  end

  string med_tab[6] = '{"PON", "OPN", "NPO", "NOP", "ONP", "PNO"};
  string lrg_tab[6] = '{"PNN", "PPN", "NPN", "NPP", "NNP", "PNP"};

  int e_sa, e_sb, e_b1, e_b2, e_b3, e_b4, e_d0;
  bit e_flag;
  string e_med, e_lrg;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic plan(int s, int tm, int tl, int st, int d0);
    bit ok = (s >= 1) && (s <= 12);
    int tmc = ok ? imin(tm, T) : 0;
    int tlc = ok ? imin(tl, T - tmc) : 0;
    int tz  = T - tmc - tlc;
    int stc = imin(st, imin(tz, T - 1));
    int d0c = imin(d0, T - 1 - stc);
    e_flag = !ok || tmc != tm || tlc != tl || stc != st || d0c != d0;
    e_sa = stc / 2;
    e_sb = stc - e_sa;
    e_b1 = tz / 2;
    e_b2 = e_b1 + tmc / 2;
    e_b3 = e_b2 + tlc;
    e_b4 = e_b3 + (tmc - tmc / 2);
    e_d0 = d0c;
    e_med = ok ? med_tab[(s - 1) / 2] : "OOO";
    e_lrg = ok ? lrg_tab[(s / 2) % 6] : "OOO";
  endtask

  task automatic compare(int p, string tag);
    bit shoot = (p < e_sa) || (p >= T - e_sb);
    string v = (p < e_b1 || p >= e_b4) ? "OOO" :
               (p < e_b2 || p >= e_b3) ? e_med : e_lrg;
    logic [2:0] xh, xm, xl;
    bit xb = (p >= e_sa) && (p < e_sa + e_d0);
    for (int g = 0; g < 3; g++) begin
      xh[g] = shoot || v.getc(g) == "P";
      xm[g] = shoot || v.getc(g) == "O";
      xl[g] = shoot || v.getc(g) == "N";
    end
    checks++;
    if ({gate_hi_o, gate_mid_o, gate_lo_o} !== {xh, xm, xl}) begin
      errors++;
      $display("FAIL %s pos %0d gates hi/mid/lo %b/%b/%b expected %b/%b/%b",
               shoot ? "R2" : tag, p, gate_hi_o, gate_mid_o, gate_lo_o, xh, xm, xl);
    end
    checks++;
    if (boost_p_o !== xb || boost_n_o !== xb) begin
      errors++;
      $display("FAIL R6 pos %0d boost %b%b expected %b", p, boost_p_o, boost_n_o, xb);
    end
    checks++;
    if (clamp_o !== e_flag) begin
      errors++;
      $display("FAIL R7 pos %0d flag %b expected %b", p, clamp_o, e_flag);
    end
  endtask

  task automatic run_period(int s, int tm, int tl, int st, int d0, string tag, bit disturb);
    sector_i = 4'(s);
    t_med_i = CW'(tm); t_lrg_i = CW'(tl); t_st_i = CW'(st); t_bst_i = CW'(d0);
    plan(s, tm, tl, st, d0);
    do @(negedge clk); while (!(ecount > 0 && ecount % T == 0));
    for (int p = 0; p < T; p++) begin
      @(negedge clk);
      compare(p, tag);
      if (disturb && p == T / 2) begin
        sector_i = 4'd7;
        t_med_i = 5'd3; t_lrg_i = 5'd3; t_st_i = 5'd14; t_bst_i = 5'd2;
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pat[5][4] = '{'{6, 4, 3, 8}, '{2, 9, 4, 5}, '{0, 0, 5, 12}, '{7, 7, 6, 7}, '{5, 6, 3, 12}};
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if ({gate_hi_o, gate_mid_o, gate_lo_o, boost_p_o, boost_n_o, clamp_o} !== 12'd0) begin
      errors++;
      $display("FAIL R10 reset outputs %b expected 0",
               {gate_hi_o, gate_mid_o, gate_lo_o, boost_p_o, boost_n_o, clamp_o});
    end
    rst_n = 1'b1;
    plan(1, 0, 0, 0, 0);
    for (int p = 0; p < T; p++) begin
      @(negedge clk);
      compare(p, "R10");
    end
    // R1 R3 R4 R5 sector and dwell sweep
    for (int s = 1; s <= 12; s++)
      for (int k = 0; k < 5; k++)
        run_period(s, pat[k][0], pat[k][1], pat[k][2], pat[k][3], "R1 R3 R4 R5", 0);
    // R7 clamps
    run_period(3, 25, 3, 2, 4, "R7", 0);
    run_period(5, 12, 12, 0, 0, "R7", 0);
    run_period(8, 5, 5, 12, 2, "R7", 0);
    run_period(2, 3, 3, 4, 31, "R7", 0);
    run_period(11, 0, 0, 31, 0, "R7", 0);
    // R9 invalid sectors
    run_period(0, 5, 5, 4, 6, "R9", 0);
    run_period(13, 5, 5, 4, 6, "R9", 0);
    run_period(15, 0, 0, 3, 3, "R9", 0);
    // R8 mid-period change ignored, then takes effect next period
    run_period(4, 6, 6, 4, 9, "R8", 1);
    run_period(9, 4, 8, 5, 10, "R8", 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule